// File: doc/BRIEF.md
# DRAM Row/Column Strobe Bank Decoder

This block drives the four active-low row strobes, the active-low column strobe and the write-enable output of a four-bank dynamic memory array. A memory access is opened by a row strobe request. The block forwards that request only to the bank or banks picked by the bank-select bits. Every other bank is left idle, which keeps its power low. A configuration input selects between two decode styles. In single-bank mode, one row strobe is driven per access. In paired mode, two row strobes are driven together, so that each strobe line carries only half the load of a wide data word.

Refresh cycles bypass the bank decode. While the refresh flag is set, every row strobe follows the row request and the column strobe is held high. Chip select can block an access, but it has no effect on refresh. The bank-select inputs pass through a latch that is transparent while the address strobe input is high and holds its value while that input is low. This lets the bus move on to other addresses during a cycle. All outputs are registered and change one clock after the inputs that cause them.

Top module: `strobe_bank_decoder`

## Requirements
- R1: While reset is asserted, and right after it is released, `rasOutN` is 4'b1111, `casOutN` is 1 and `weOutN` is 1.
- R2: With `pairedMode`=0, `refreshActive`=0 and `chipSelN`=0, only `rasOutN[b]` follows `rasInN`, where b is the latched bank value (0 to 3). The other three RAS outputs stay high.
- R3: With `pairedMode`=1 in an access, latched bank bit 1 = 0 makes `rasOutN[0]` and `rasOutN[1]` follow `rasInN`. Bank bit 1 = 1 makes `rasOutN[2]` and `rasOutN[3]` follow it. Bank bit 0 has no effect.
- R4: While `refreshActive`=1, all four RAS outputs follow `rasInN`, whatever the values of `chipSelN`, the bank bits and the mode.
- R5: With `chipSelN`=1 and `refreshActive`=0, all RAS outputs and `casOutN` are high.
- R6: While `refreshActive`=1, `casOutN` is high.
- R7: In an access, `casOutN` follows `casInN` while `rowColSel`=0 (column phase) and is high while `rowColSel`=1 (row phase).
- R8: `weOutN` follows `weInN` in every mode, during refresh and with the chip deselected.
- R9: While `addrStrobe`=1 the bank latch is transparent. While `addrStrobe`=0 it keeps the value it sampled in the last cycle the strobe was high, so later changes on `bankSel` do not move the active RAS.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasInN | input | 1 | Row strobe request, active low |
| casInN | input | 1 | Column strobe request, active low |
| rowColSel | input | 1 | 1 = row phase, 0 = column phase |
| chipSelN | input | 1 | Chip select, active low |
| bankSel | input | 2 | Bank select bits |
| addrStrobe | input | 1 | Bank latch enable, transparent when high |
| refreshActive | input | 1 | Refresh cycle in progress |
| pairedMode | input | 1 | 1 = paired bank decode |
| weInN | input | 1 | Write enable request |
| rasOutN | output | 4 | Row strobes, active low |
| casOutN | output | 1 | Column strobe, active low |
| weOutN | output | 1 | Write enable output |

## Verification
The properties assume that every input is stable at the rising edge and may change only between edges. They also assume that `pairedMode` does not change in the middle of an access, so that the decode seen one cycle later matches the mode that was sampled. The stimulus follows these rules by changing every input on the falling clock edge. It also holds `pairedMode` constant within each group of single-bank or paired steps, and only changes it between groups, while the chip is deselected.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;
  // Strobe commands passed from control to datapath
  typedef struct packed {
    logic rasAll;   // refresh: every row strobe enabled
    logic rasSel;   // access: only decoded banks enabled
    logic casGate;  // column strobe may follow its request
  } strobeCtl_t;
endpackage

// File: rtl/strobe_ctl.sv
module strobe_ctl
  import strobe_dec_pkg::*;
(
  input  logic       refreshActive,
  input  logic       chipSelN,
  input  logic       rowColSel,
  output strobeCtl_t ctl
);
  logic accessOn;

  // Refresh wins over access; chip select gates accesses only
  assign accessOn    = !refreshActive && !chipSelN;
  assign ctl.rasAll  = refreshActive;
  assign ctl.rasSel  = accessOn;
  assign ctl.casGate = accessOn && !rowColSel;
endmodule

// File: rtl/strobe_dp.sv
module strobe_dp
  import strobe_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeCtl_t           ctl,
  input  logic                 rasInN,
  input  logic                 casInN,
  input  logic                 weInN,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 addrStrobe,
  input  logic                 pairedMode,
  output logic [NUM_BANKS-1:0] rasOutN,
  output logic                 casOutN,
  output logic                 weOutN
);
  logic [BANK_W-1:0]    bankHeld;
  logic [BANK_W-1:0]    effBank;
  logic [NUM_BANKS-1:0] bankHit;
  logic [NUM_BANKS-1:0] rasNext;
  logic                 casNext;

  // Fall-through bank latch: transparent while the strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bankHeld <= '0;
    else if (addrStrobe) bankHeld <= bankSel;
  end

  assign effBank = addrStrobe ? bankSel : bankHeld;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam logic [BANK_W-1:0] IDX = BANK_W'(i);
    // Paired mode compares only the top bank bit
    assign bankHit[i] = pairedMode ? (IDX[BANK_W-1] == effBank[BANK_W-1])
                                   : (IDX == effBank);
    assign rasNext[i] = rasInN | ~(ctl.rasAll | (ctl.rasSel & bankHit[i]));
  end

  assign casNext = casInN | ~ctl.casGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasOutN <= '1;
      casOutN <= 1'b1;
      weOutN  <= 1'b1;
    end else begin
      rasOutN <= rasNext;
      casOutN <= casNext;
      weOutN  <= weInN;
    end
  end
endmodule

// File: rtl/strobe_bank_decoder.sv
module strobe_bank_decoder
  import strobe_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasInN,
  input  logic       casInN,
  input  logic       rowColSel,
  input  logic       chipSelN,
  input  logic [1:0] bankSel,
  input  logic       addrStrobe,
  input  logic       refreshActive,
  input  logic       pairedMode,
  input  logic       weInN,
  output logic [3:0] rasOutN,
  output logic       casOutN,
  output logic       weOutN
);
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  strobeCtl_t ctl;

  strobe_ctl u_ctl (
    .refreshActive(refreshActive),
    .chipSelN     (chipSelN),
    .rowColSel    (rowColSel),
    .ctl          (ctl)
  );

  strobe_dp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rasInN    (rasInN),
    .casInN    (casInN),
    .weInN     (weInN),
    .bankSel   (bankSel),
    .addrStrobe(addrStrobe),
    .pairedMode(pairedMode),
    .rasOutN   (rasOutN),
    .casOutN   (casOutN),
    .weOutN    (weOutN)
  );
endmodule

// File: rtl/strobe_bank_decoder_chk.sv
module strobe_bank_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rasInN,
  input logic       casInN,
  input logic       rowColSel,
  input logic       chipSelN,
  input logic [1:0] bankSel,
  input logic       addrStrobe,
  input logic       refreshActive,
  input logic       pairedMode,
  input logic       weInN,
  input logic [3:0] rasOutN,
  input logic       casOutN,
  input logic       weOutN
);
  assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshActive && !pairedMode) |=> ($countones(~rasOutN) <= 1));

  assert_pair_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshActive && pairedMode) |=>
      (rasOutN[0] == rasOutN[1]) && (rasOutN[2] == rasOutN[3]));

  assert_refresh_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    refreshActive |=> (rasOutN == {4{$past(rasInN)}}));

  assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN && !refreshActive) |=> (&rasOutN && casOutN));

  assert_refresh_cas_R6: assert property (@(posedge clk) disable iff (!rstN)
    refreshActive |=> casOutN);

  assert_cas_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshActive && !chipSelN && !rowColSel) |=> (casOutN == $past(casInN)));

  assert_we_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (weOutN == $past(weInN)));
endmodule

bind strobe_bank_decoder strobe_bank_decoder_chk u_chk (.*);

// File: tb/sim_strobe_bank_decoder.sv
`timescale 1ns/1ps
module sim_strobe_bank_decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasInN = 1'b1, casInN = 1'b1, rowColSel = 1'b1, chipSelN = 1'b1;
  logic [1:0] bankSel = 2'd0;
  logic       addrStrobe = 1'b1, refreshActive = 1'b0, pairedMode = 1'b0, weInN = 1'b1;
  logic [3:0] rasOutN;
  logic       casOutN, weOutN;

  typedef struct {
    logic [3:0] ras;
    logic       cas;
    logic       we;
    string      req;
  } expItem_t;

  expItem_t   expQ[$];
  int         checkCount = 0;
  int         failCount = 0;
  logic [1:0] modelHeld = 2'd0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  strobe_bank_decoder u0 (
    .clk(clk), .rstN(rstN), .rasInN(rasInN), .casInN(casInN),
    .rowColSel(rowColSel), .chipSelN(chipSelN), .bankSel(bankSel),
    .addrStrobe(addrStrobe), .refreshActive(refreshActive),
    .pairedMode(pairedMode), .weInN(weInN),
    .rasOutN(rasOutN), .casOutN(casOutN), .weOutN(weOutN)
  );

  // Driver: apply inputs on the falling edge and queue the expected result
  task automatic step(input logic ras, input logic cas, input logic rc,
                      input logic cs, input logic [1:0] bank, input logic ads,
                      input logic rf, input logic pm, input logic we,
                      input string req);
    expItem_t   it;
    logic [1:0] eff;
    @(negedge clk);
    rasInN = ras; casInN = cas; rowColSel = rc; chipSelN = cs;
    bankSel = bank; addrStrobe = ads; refreshActive = rf;
    pairedMode = pm; weInN = we;
    eff = ads ? bank : modelHeld;
    if (ads) modelHeld = bank;
    it.ras = 4'b1111;
    it.cas = 1'b1;
    if (rf) begin
      it.ras = {4{ras}};
    end else if (!cs) begin
      for (int i = 0; i < 4; i++) begin
        if (pm ? (i[1] == eff[1]) : (i[1:0] == eff)) it.ras[i] = ras;
      end
      if (!rc) it.cas = cas;
    end
    it.we  = we;
    it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compare one item per clock, after the outputs settle
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checkCount++;
      if (rasOutN !== it.ras || casOutN !== it.cas || weOutN !== it.we) begin
        failCount++;
        $display("FAIL %s: actual ras=%b cas=%b we=%b expected ras=%b cas=%b we=%b",
                 it.req, rasOutN, casOutN, weOutN, it.ras, it.cas, it.we);
      end
    end
  end

  task automatic checkReset(input string tag);
    checkCount++;
    if (rasOutN !== 4'b1111 || casOutN !== 1'b1 || weOutN !== 1'b1) begin
      failCount++;
      $display("FAIL %s: actual ras=%b cas=%b we=%b expected ras=1111 cas=1 we=1",
               tag, rasOutN, casOutN, weOutN);
    end
  endtask

  initial begin
    // R1: reset state
    weInN = 1'b0; rasInN = 1'b0;
    repeat (3) @(negedge clk);
    checkReset("R1");
    rstN = 1'b1;
    weInN = 1'b1; rasInN = 1'b1;
    @(posedge clk); #1;
    checkReset("R1");

    // R2 / R10: single-bank decode, each bank in turn
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 2'(b), 1'b1, 1'b0, 1'b0, 1'b1, "R2");
      step(1'b1, 1'b1, 1'b1, 1'b0, 2'(b), 1'b1, 1'b0, 1'b0, 1'b1, "R10");
    end
    // R7: column phase follows casInN, row phase keeps CAS high
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    // R9: latch bank 2, then bankSel moves while addrStrobe is low
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    // R5: deselected, row and column requests active
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    // R3: paired decode, bank bit 0 toggled to show it is ignored
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 2'(b), 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    // R4 / R6: refresh with the chip deselected and selected, in both modes
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      failCount++;
      $display("FAIL R10: watchdog expired, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule